// File: doc/BRIEF.md
# Carry-Skip Adder/Subtractor

This block is a purely combinational add/subtract unit for two unsigned 10-bit magnitudes. A single control bit selects the operation. With the bit clear the unit forms the sum of the two operands. With it set the unit forms the first operand minus the second. For subtraction it inverts every bit of the second operand and injects the control bit as the carry into the least significant stage, so it computes the two's-complement difference with the same adder.

Each bit stage derives three carry terms: propagate, generate and kill. The stages are chained in ripple fashion inside skip groups. The groups are 3, 3, 3 and 1 bits wide, counted from bit 0 upward. When every stage of a group propagates, a per-group multiplexer sends the group's incoming carry straight to its outgoing carry. The carry-out has two meanings. After an addition it flags unsigned overflow. After a subtraction it flags a valid result, which means the minuend was not smaller than the subtrahend. A caller whose result must never go negative uses it as an error indication.

Top module: `csk_addsub`

## Requirements
- R1: With subMode = 0, result equals (opY + opX) mod 1024 for all operand values.
- R2: With subMode = 0, carryOut is 1 exactly when opY + opX is 1024 or more.
- R3: With subMode = 1, result equals (opY - opX) mod 1024, that is opY + ~opX + 1 with the 2^10 term dropped.
- R4: With subMode = 1, carryOut is 1 when opY >= opX (result valid) and 0 when opX > opY (result invalid).
- R5: When all propagate terms of a group are high, the group's carry-out equals its carry-in. A full-length propagate chain therefore delivers the initial carry to carryOut, for example when subtracting equal operands (result 0, carryOut 1).
- R6: A bit position where both adder inputs are 0 (kill) stops an incoming carry: the carry above it is 0. Example: 0x0FF + 0x001 gives 0x100 with carryOut 0.
- R7: The skip groups cover bits [2:0], [5:3], [8:6] and [9]. A carry that ripples out of the [8:6] group reaches bit 9 and carryOut correctly, for example 0x1C0 + 0x040 = 0x200, and 0x3C0 + 0x040 gives 0x000 with carryOut 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opY | input | 10 | First operand (minuend when subtracting) |
| opX | input | 10 | Second operand (subtrahend when subtracting) |
| subMode | input | 1 | 0 = add, 1 = subtract; typically an operand's sign bit |
| result | output | 10 | Sum or difference modulo 1024 |
| carryOut | output | 1 | Overflow after addition; valid flag after subtraction |

## Verification
Every result of this block is due in the same cycle as its stimulus, zero clock edges later, because no register lies between the operands and result or carryOut. The bench drives each vector on a rising clock edge and samples result and carryOut half a period later on the falling edge. The combinational carry and skip paths have settled by then, and no sample coincides with an edge where a new vector is applied. Expected values come from integer arithmetic on 11-bit quantities in the bench, never from the design's carry signals.

// File: rtl/csk_pkg.sv
package csk_pkg;
  localparam int DataWidth  = 10;
  localparam int GroupWidth = 3;

  typedef struct packed {
    logic invertX;
    logic carryIn;
  } ctlStrobe_t;
endpackage

// File: rtl/csk_bit_stage.sv
module csk_bit_stage (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic prop,
  output logic sum,
  output logic cout
);
  logic gen;
  logic kill;

  always_comb begin
    prop = a ^ b;
    gen  = a & b;
    kill = ~a & ~b;
    sum  = prop ^ cin;
    if (gen)       cout = 1'b1;
    else if (kill) cout = 1'b0;
    else           cout = cin;
  end
endmodule

// File: rtl/csk_skip_group.sv
module csk_skip_group #(
  parameter int GW = 3
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          cout
);
  logic [GW:0]   rip;
  logic [GW-1:0] prop;
  logic          allProp;

  assign rip[0] = cin;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    csk_bit_stage u_bit (
      .a   (a[i]),
      .b   (b[i]),
      .cin (rip[i]),
      .prop(prop[i]),
      .sum (sum[i]),
      .cout(rip[i+1])
    );
  end

  // explicit skip multiplexer
  always_comb begin
    allProp = &prop;
    cout    = allProp ? cin : rip[GW];
  end

  always_comb begin
    if (allProp) begin
      a_r5_skip_pass : assert (cout == cin);
    end
    if (!a[GW-1] && !b[GW-1]) begin
      a_r6_kill_blocks : assert (cout == 1'b0);
    end
  end
endmodule

// File: rtl/csk_control.sv
module csk_control
  import csk_pkg::*;
(
  input  logic       subMode,
  output ctlStrobe_t strobe
);
  always_comb begin
    strobe.invertX = subMode;
    strobe.carryIn = subMode;
  end
endmodule

// File: rtl/csk_datapath.sv
module csk_datapath
  import csk_pkg::*;
#(
  parameter int W = DataWidth,
  parameter int G = GroupWidth
) (
  input  logic [W-1:0] opY,
  input  logic [W-1:0] opX,
  input  ctlStrobe_t   strobe,
  output logic [W-1:0] result,
  output logic         carryOut
);
  localparam int NumGroups = (W + G - 1) / G;

  logic [W-1:0]       xEff;
  logic [NumGroups:0] grpCarry;

  assign xEff        = opX ^ {W{strobe.invertX}};
  assign grpCarry[0] = strobe.carryIn;

  for (genvar g = 0; g < NumGroups; g++) begin : g_grp
    localparam int Lo = g * G;
    localparam int Hi = ((Lo + G) < W) ? (Lo + G - 1) : (W - 1);
    localparam int Gw = Hi - Lo + 1;

    csk_skip_group #(.GW(Gw)) u_grp (
      .a   (opY[Hi:Lo]),
      .b   (xEff[Hi:Lo]),
      .cin (grpCarry[g]),
      .sum (result[Hi:Lo]),
      .cout(grpCarry[g+1])
    );
  end

  assign carryOut = grpCarry[NumGroups];
endmodule

// File: rtl/csk_addsub.sv
module csk_addsub
  import csk_pkg::*;
#(
  parameter int W = DataWidth,
  parameter int G = GroupWidth
) (
  input  logic [W-1:0] opY,
  input  logic [W-1:0] opX,
  input  logic         subMode,
  output logic [W-1:0] result,
  output logic         carryOut
);
  ctlStrobe_t strobe;

  csk_control u_ctl (
    .subMode(subMode),
    .strobe (strobe)
  );

  csk_datapath #(.W(W), .G(G)) u_dp (
    .opY     (opY),
    .opX     (opX),
    .strobe  (strobe),
    .result  (result),
    .carryOut(carryOut)
  );

  always_comb begin
    if (!subMode) begin
      a_r1_sum_value : assert (result == W'(opY + opX));
      a_r2_overflow  : assert (carryOut == ({1'b0, opY} + {1'b0, opX} > {1'b0, {W{1'b1}}}));
    end else begin
      a_r3_diff_value : assert (result == W'(opY - opX));
      a_r4_valid_flag : assert (carryOut == (opY >= opX));
    end
  end
endmodule

// File: tb/sim_csk_addsub.sv
module sim_csk_addsub;
  localparam int ClkPeriod = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opY = '0;
  logic [W-1:0] opX = '0;
  logic subMode = 1'b0;
  logic [W-1:0] result;
  logic carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  csk_addsub u0 (
    .opY     (opY),
    .opX     (opX),
    .subMode (subMode),
    .result  (result),
    .carryOut(carryOut)
  );

  task automatic apply(input logic [W-1:0] y, input logic [W-1:0] x, input logic s);
    @(posedge clk);
    opY = y; opX = x; subMode = s;
    @(negedge clk);
  endtask

  task automatic expectOut(input string tag, input logic [W-1:0] er, input logic ec);
    nChecks++;
    if (result !== er || carryOut !== ec) begin
      nFails++;
      $display("FAIL %s: y=%h x=%h sub=%b got result=%h carry=%b expected result=%h carry=%b",
               tag, opY, opX, subMode, result, carryOut, er, ec);
    end
  endtask

  // reference from integer arithmetic
  task automatic checkVec(input string tag, input logic [W-1:0] y, input logic [W-1:0] x, input logic s);
    int ey;
    apply(y, x, s);
    if (!s) begin
      ey = int'(y) + int'(x);
      expectOut(tag, ey[W-1:0], ey >= 1024);
    end else begin
      ey = int'(y) - int'(x) + 1024;
      expectOut(tag, ey[W-1:0], int'(y) >= int'(x));
    end
  endtask

  task automatic tIdle();
    apply('0, '0, 1'b0);
    expectOut("R1 zero operands", '0, 1'b0);
  endtask

  task automatic tAddCorners();
    checkVec("R1 add small", 10'd5, 10'd7, 1'b0);
    checkVec("R2 add max+1", 10'h3FF, 10'h001, 1'b0);
    checkVec("R2 add max+max", 10'h3FF, 10'h3FF, 1'b0);
    checkVec("R2 add 512+512", 10'h200, 10'h200, 1'b0);
    checkVec("R1 add 511+512", 10'h1FF, 10'h200, 1'b0);
  endtask

  task automatic tSubCorners();
    checkVec("R3 sub basic", 10'd100, 10'd37, 1'b1);
    checkVec("R4 sub invalid", 10'd3, 10'd4, 1'b1);
    checkVec("R4 sub 0-max", 10'h000, 10'h3FF, 1'b1);
    checkVec("R3 sub max-0", 10'h3FF, 10'h000, 1'b1);
    checkVec("R4 sub max-1", 10'h3FF, 10'h001, 1'b1);
  endtask

  task automatic tSkipChain();
    apply(10'h2A5, 10'h2A5, 1'b1);
    expectOut("R5 equal subtract full skip", 10'h000, 1'b1);
    apply(10'h3FF, 10'h000, 1'b0);
    expectOut("R5 all propagate no carry", 10'h3FF, 1'b0);
    apply(10'h155, 10'h155, 1'b1);
    expectOut("R5 equal subtract pattern", 10'h000, 1'b1);
  endtask

  task automatic tKill();
    apply(10'h0FF, 10'h001, 1'b0);
    expectOut("R6 kill at bit 8", 10'h100, 1'b0);
    apply(10'h007, 10'h001, 1'b0);
    expectOut("R6 kill at bit 3", 10'h008, 1'b0);
  endtask

  task automatic tGroupEdge();
    apply(10'h1C0, 10'h040, 1'b0);
    expectOut("R7 carry into bit 9", 10'h200, 1'b0);
    apply(10'h3C0, 10'h040, 1'b0);
    expectOut("R7 carry through bit 9", 10'h000, 1'b1);
    apply(10'h038, 10'h008, 1'b0);
    expectOut("R7 carry into group 2", 10'h040, 1'b0);
  endtask

  task automatic tSweep();
    for (int y = 0; y < 1024; y++) begin
      for (int x = 0; x < 1024; x += 97) begin
        checkVec("R1 sweep add", W'(y), W'(x), 1'b0);
        checkVec("R3 sweep sub", W'(y), W'(x), 1'b1);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    tIdle();
    tAddCorners();
    tSubCorners();
    tSkipChain();
    tKill();
    tGroupEdge();
    tSweep();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule